// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

The block divides a 32768 Hz reference down to one of thirteen power-of-two rates, from 8192 Hz to 2 Hz, picked by a 4-bit rate code. The selected rate drives a square-wave pin and raises a periodic flag once per full period. When the periodic-interrupt enable is set, that flag also drives the interrupt request. Two rate codes are aliases of slower codes, and code zero stops the generator. A separate override makes the pin carry the raw 32768 Hz reference and blocks the periodic flag.

The reference arrives as a level that is synchronous to the system clock. A rising edge of the reference advances the divider by one step. Host logic reads the flags through a one-cycle read strobe. During that cycle the read byte shows the flags, and at the following edge the periodic flag is cleared.

Top module: `periodic_wave_gen`

## Requirements
- R1: After reset, `sqw_out`, `pflag` and `irq` are 0.
- R2: For rate code c in 3..15, one full period is 2^(c-1) reference rising edges. The divider count runs from 0 after each restart. `sqw_out` is high exactly when bit (c-2) of that count is 1.
- R3: Rate code 0 holds `sqw_out` low (unless overridden) and never sets `pflag`.
- R4: Rate codes 1 and 2 behave exactly as codes 8 and 9.
- R5: While `ovr_full` is 1, `sqw_out` equals the `ref_32k` level of the previous clock cycle, whatever the rate code or `sqw_en`. No periodic flag is set while `ovr_full` is 1.
- R6: With `ovr_full` at 0 and `sqw_en` at 0, `sqw_out` is held low.
- R7: `pflag` is set at the reference edge that completes each full period, whatever the value of `pie`. `irq` equals `pflag` AND `pie`.
- R8: In a cycle with `flag_rd` high, `flag_rdata` returns `irq` in bit 7 and `pflag` in bit 6, with bits 5..0 at zero. `pflag` clears at the next edge, unless a new period ends in that same cycle, in which case the flag stays set.
- R9: Any change of `rate_sel` resets the divider count to zero, so a new full period starts from the first reference edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_32k | input | 1 | 32768 Hz reference level, synchronous to clk |
| rate_sel | input | 4 | Rate code |
| sqw_en | input | 1 | Square-wave output enable |
| pie | input | 1 | Periodic interrupt enable |
| ovr_full | input | 1 | Put full reference rate on the pin and block the periodic flag |
| flag_rd | input | 1 | Flag read strobe (read clears) |
| sqw_out | output | 1 | Square-wave level |
| pflag | output | 1 | Periodic flag |
| irq | output | 1 | Interrupt request |
| flag_rdata | output | 8 | Flag byte: bit 7 request, bit 6 periodic |

## Verification
The bench uses the default `CNT_W` of 14, which holds the full 16384-edge period of the 2 Hz code. It toggles the reference every cycle, so one rising edge arrives every two cycles. This brings a complete period of every code, including the slowest, within the cycle budget.

The bench sweeps all sixteen codes with alternating interrupt enables. It also covers a slower, irregular reference pattern, the disabled pin, the override with active and stopped codes, a mid-period code change, and back-to-back reads on the fastest code, where reads collide with new flags.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int unsigned RATE_W = 4;

  // Codes 1 and 2 stand in for codes 8 and 9
  function automatic logic [RATE_W-1:0] alias_code(input logic [RATE_W-1:0] raw);
    logic [RATE_W-1:0] res;
    case (raw)
      4'd1:    res = 4'd8;
      4'd2:    res = 4'd9;
      default: res = raw;
    endcase
    return res;
  endfunction

  // log2 of reference edges per full period
  function automatic logic [RATE_W-1:0] period_log2(input logic [RATE_W-1:0] code);
    return code - 4'd1;
  endfunction

  // count bit that carries the square wave
  function automatic logic [RATE_W-1:0] wave_tap(input logic [RATE_W-1:0] code);
    return code - 4'd2;
  endfunction
endpackage

// File: rtl/pwg_edge.sv
module pwg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_lvl,
  output logic tick
);
  logic ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_lvl;
  end

  assign tick = ref_lvl & ~ref_q;
endmodule

// File: rtl/pwg_divider.sv
module pwg_divider #(
  parameter int unsigned CNT_W = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [pwg_pkg::RATE_W-1:0] rate_sel,
  output logic [CNT_W-1:0]          cnt_nxt,
  output logic                      active,
  output logic                      period_end
);
  import pwg_pkg::*;

  logic [RATE_W-1:0] code_q;
  logic [RATE_W-1:0] eff;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  mask;
  logic              restart;

  assign eff     = alias_code(rate_sel);
  assign active  = (eff != '0);
  assign restart = (rate_sel != code_q);
  assign mask    = (CNT_W'(1) << period_log2(eff)) - CNT_W'(1);

  always_comb begin
    if (restart || !active) cnt_nxt = '0;
    else if (tick)          cnt_nxt = cnt + CNT_W'(1);
    else                    cnt_nxt = cnt;
  end

  assign period_end = tick & active & ~restart & ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      code_q <= '0;
    end else begin
      cnt    <= cnt_nxt;
      code_q <= rate_sel;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R9
  AST_PERIOD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> ((cnt & $past(mask)) == '0)); // R2
endmodule

// File: rtl/pwg_flags.sv
module pwg_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_evt,
  input  logic       ovr,
  input  logic       rd,
  input  logic       pie,
  output logic       pf,
  output logic       irq,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) pf <= 1'b0;
    else        pf <= (pf & ~rd) | (set_evt & ~ovr);
  end

  assign irq     = pf & pie;
  assign rd_data = {irq, pf, 6'b0};

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !set_evt) |=> !pf); // R8
  AST_NO_FLAG_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf) |-> !$past(ovr)); // R5
endmodule

// File: rtl/periodic_wave_gen.sv
module periodic_wave_gen #(
  parameter int unsigned CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_32k,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       pie,
  input  logic       ovr_full,
  input  logic       flag_rd,
  output logic       sqw_out,
  output logic       pflag,
  output logic       irq,
  output logic [7:0] flag_rdata
);
  import pwg_pkg::*;

  logic             tick;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] shifted;
  logic             active;
  logic             period_end;
  logic             wave;
  logic             sqw_d;

  pwg_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_lvl(ref_32k),
    .tick   (tick)
  );

  pwg_divider #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rate_sel  (rate_sel),
    .cnt_nxt   (cnt_nxt),
    .active    (active),
    .period_end(period_end)
  );

  assign shifted = cnt_nxt >> wave_tap(alias_code(rate_sel));
  assign wave    = active & shifted[0];

  always_comb begin
    if (ovr_full)    sqw_d = ref_32k;
    else if (sqw_en) sqw_d = wave;
    else             sqw_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sqw_out <= 1'b0;
    else        sqw_out <= sqw_d;
  end

  pwg_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(period_end),
    .ovr    (ovr_full),
    .rd     (flag_rd),
    .pie    (pie),
    .pf     (pflag),
    .irq    (irq),
    .rd_data(flag_rdata)
  );

  AST_CODE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0 && !ovr_full) |=> !sqw_out); // R3
  AST_EN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sqw_en && !ovr_full) |=> !sqw_out); // R6
  AST_OVR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_full |=> (sqw_out == $past(ref_32k))); // R5
endmodule

// File: tb/test_periodic_wave_gen.sv
module test_periodic_wave_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       r = 1'b0;
  logic [3:0] rs = 4'd0;
  logic       en = 1'b0, pi = 1'b0, ov = 1'b0, rd = 1'b0;
  logic       sqw, pf, irq;
  logic [7:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  int  m_cnt = 0;
  bit  m_pf = 0;
  bit  prev_ref = 0;
  int  prev_rate = 0;
  bit  last_restart = 0;

  always #4 clk = ~clk;

  periodic_wave_gen i_periodic_wave_gen (
    .clk(clk), .rst_n(rst_n), .ref_32k(r), .rate_sel(rs), .sqw_en(en),
    .pie(pi), .ovr_full(ov), .flag_rd(rd), .sqw_out(sqw), .pflag(pf),
    .irq(irq), .flag_rdata(rdata)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int eff_of(input int code);
    if (code == 1) return 8;
    if (code == 2) return 9;
    return code;
  endfunction

  // one clock cycle: inputs already set except the reference level
  task automatic cyc(input bit rv);
    int e, n, exp_sqw;
    bit tk, act, restart, pe;
    string tag, ftag;
    r = rv;
    #1;
    if (rd) chk("R8", "flag byte", rdata, ((m_pf && pi) ? 128 : 0) + (m_pf ? 64 : 0));
    @(posedge clk);
    e = eff_of(rs);
    act = (e != 0);
    n = act ? (1 << (e - 1)) : 1;
    tk = rv && !prev_ref;
    restart = (int'(rs) != prev_rate);
    pe = tk && act && !restart && (((m_cnt + 1) % n) == 0);
    if (restart || !act) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1) % 16384;
    if (ov) exp_sqw = rv;
    else if (en && act) exp_sqw = (m_cnt / (n / 2)) % 2;
    else exp_sqw = 0;
    m_pf = (m_pf && !rd) || (pe && !ov);
    prev_ref = rv;
    prev_rate = rs;
    @(negedge clk);
    if (ov) tag = "R5";
    else if (!act) tag = "R3";
    else if (!en) tag = "R6";
    else if (restart || last_restart) tag = "R9";
    else if (rs == 1 || rs == 2) tag = "R4";
    else tag = "R2";
    last_restart = restart;
    ftag = ov ? "R5" : (!act ? "R3" : "R7");
    chk(tag, "sqw_out", sqw, exp_sqw);
    chk(ftag, "pflag", pf, m_pf);
    chk("R7", "irq", irq, m_pf && pi);
  endtask

  task automatic run(input int ncyc, input int rd_every, input int ref_mode);
    for (int i = 0; i < ncyc; i++) begin
      rd = (rd_every > 0) && ((i % rd_every) == rd_every - 1);
      cyc(ref_mode == 0 ? bit'(i % 2) : bit'((i % 3) == 0));
    end
    rd = 1'b0;
  endtask

  initial begin
    #(8 * 199000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "sqw_out after reset", sqw, 0);
    chk("R1", "pflag after reset", pf, 0);
    chk("R1", "irq after reset", irq, 0);

    // sweep every rate code, one full period plus margin, R2 R3 R4 R7
    en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      int e2, per;
      rs = c[3:0];
      pi = c[0];
      e2 = eff_of(c);
      per = (e2 == 0) ? 40 : (1 << (e2 - 1));
      run(2 * per + 12, 53, 0);
    end
    // irregular reference spacing, R2
    rs = 4'd4; pi = 1'b1;
    run(120, 17, 1);
    // disabled pin, R6
    en = 1'b0; rs = 4'd5;
    run(80, 0, 0);
    // override on running and stopped codes, R5
    ov = 1'b1; en = 1'b1; rs = 4'd3;
    run(40, 7, 0);
    en = 1'b0; rs = 4'd0;
    run(20, 0, 1);
    ov = 1'b0; rs = 4'd6; en = 1'b1;
    run(40, 0, 0);
    // mid-period code change, R9
    rs = 4'd7;
    run(300, 0, 0);
    // reads on every cycle, colliding with new flags, R8
    rs = 4'd3; pi = 1'b1;
    run(60, 1, 0);
    run(20, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule